// File: doc/BRIEF.md
# Byte-Wide Eight-Chain JTAG Bit-Bang Bridge

This block sits as a slave on a simple parallel register bus. It steers eight separate JTAG chains in lockstep: bit i of the bus byte always belongs to chain i. Software programs the next TDI bits and TMS bits with two writes, then requests one shift step. The bridge produces that step's TCK pulse on all eight chains at once, and it captures the eight TDO bits at the same moment. All chains are therefore advanced together by plain register accesses, with no shift engine inside the block.

A 3-bit operation code comes with every access. Code 0 loads the TDI byte. Code 1 loads the TMS byte. Code 2 requests a TCK step on a write and returns status on a read. Code 3 returns the captured TDO byte. While a step is running, a busy flag is held. Any write that arrives during that time is discarded and sets a sticky error flag. A read of code 3 clears that flag. The length of the TCK pulse, counted in system clocks, is a parameter.

Top module: `jtag_bridge`

## Requirements
- R1: While reset is asserted and after it is released, tck is 0, tms is all ones, tdi is 0, busy is 0, wr_err is 0 and bus_rdata is 0.
- R2: A write with op 0 while idle puts bus_wdata onto tdi from the next cycle on, with bit i driving chain i.
- R3: A write with op 1 while idle puts bus_wdata onto tms from the next cycle on, with bit i driving chain i.
- R4: A write with op 2 while idle raises busy and tck in the next cycle. tck then stays high for TCK_HALF clocks and low for TCK_HALF clocks. busy stays high for all 2*TCK_HALF clocks.
- R5: The tdo byte is captured on the clock edge that accepts the op 2 write, which is the edge where tck rises. The captured byte is held until the next accepted step, whatever tdo does in the meantime.
- R6: Any write, with any op, in a cycle where busy is high is discarded: tdi, tms and the pulse timing stay unchanged, and wr_err is set from the next cycle on.
- R7: A read with op 3 clears wr_err in the next cycle. If a discarded write lands in the same cycle, wr_err stays set, because setting takes priority over clearing.
- R8: bus_rdata is registered: a read returns its value one cycle after the strobe, and bus_rdata is 0 in cycles that follow no read. Op 0 returns tdi. Op 1 returns tms. Op 2 returns busy in bit 0 and wr_err in bit 1, with the other bits 0. Op 3 returns the captured TDO byte. Ops 4 to 7 return 0.
- R9: A write with op 3 to 7 while idle changes no output and does not set wr_err.
- R10: tdi and tms do not change while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_op | input | 3 | Operation code for the access |
| bus_wdata | input | NCHAIN | Write data, one bit per chain |
| bus_rdata | output | NCHAIN | Registered read data |
| busy | output | 1 | A TCK step is in progress |
| wr_err | output | 1 | Sticky flag: a write was discarded |
| tck | output | 1 | Common TCK for all chains |
| tms | output | NCHAIN | TMS per chain |
| tdi | output | NCHAIN | TDI per chain |
| tdo | input | NCHAIN | TDO per chain |

## Verification
Two events can fall on the same clock edge: a discarded write that sets the error flag, and a read of op 3 that clears it. The bench drives a write and an op 3 read in a single cycle while a step is running, then checks that the flag stays set, since setting wins. The bench also places an op 2 write exactly on the last busy cycle of a step, where it must be dropped, and another write on the first idle cycle, where it must start a new step. A behavioural model counts the pulse length and is compared with every output on every clock.

// File: rtl/jtag_bridge_pkg.sv
package jtag_bridge_pkg;
   localparam int OP_W = 3;

   localparam logic [OP_W-1:0] OP_SET_TDI = 3'd0;
   localparam logic [OP_W-1:0] OP_SET_TMS = 3'd1;
   localparam logic [OP_W-1:0] OP_STEP    = 3'd2;
   localparam logic [OP_W-1:0] OP_GET_TDO = 3'd3;

   typedef struct packed {
      logic ld_tdi;
      logic ld_tms;
      logic step;
      logic drop;
      logic clr_err;
   } strobe_t;
endpackage

// File: rtl/jtag_bridge_decode.sv
module jtag_bridge_decode
   import jtag_bridge_pkg::*;
(
   input  logic            wr,
   input  logic            rd,
   input  logic [OP_W-1:0] op,
   input  logic            busy,
   output strobe_t         stb
);
   logic wr_ok;

   always_comb begin
      wr_ok       = wr && !busy;
      stb.ld_tdi  = wr_ok && (op == OP_SET_TDI);
      stb.ld_tms  = wr_ok && (op == OP_SET_TMS);
      stb.step    = wr_ok && (op == OP_STEP);
      stb.drop    = wr && busy;
      stb.clr_err = rd && (op == OP_GET_TDO);
   end
endmodule

// File: rtl/jtag_bridge_tckgen.sv
module jtag_bridge_tckgen #(
   parameter int TCK_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic tck,
   output logic busy
);
   logic hi_q;
   logic act_q;

   generate
      if (TCK_HALF == 1) begin : g_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q  <= 1'b0;
               act_q <= 1'b0;
            end else if (step) begin
               hi_q  <= 1'b1;
               act_q <= 1'b1;
            end else if (act_q) begin
               if (hi_q) hi_q  <= 1'b0;
               else      act_q <= 1'b0;
            end
         end
      end else begin : g_count
         localparam int CW = $clog2(TCK_HALF);
         localparam logic [CW-1:0] LAST = CW'(TCK_HALF - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q  <= 1'b0;
               act_q <= 1'b0;
               cnt_q <= '0;
            end else if (step) begin
               hi_q  <= 1'b1;
               act_q <= 1'b1;
               cnt_q <= '0;
            end else if (act_q) begin
               if (cnt_q == LAST) begin
                  cnt_q <= '0;
                  if (hi_q) hi_q  <= 1'b0;
                  else      act_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   endgenerate

   assign tck  = hi_q;
   assign busy = act_q;

   assert_tck_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tck |-> busy);
   assert_step_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !busy) |=> (tck && busy));
   assert_low_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tck) |-> busy);
endmodule

// File: rtl/jtag_bridge_capture.sv
module jtag_bridge_capture #(
   parameter int NCHAIN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [NCHAIN-1:0] tdo,
   output logic [NCHAIN-1:0] cap
);
   generate
      for (genvar i = 0; i < NCHAIN; i++) begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cap[i] <= 1'b0;
            else if (take) cap[i] <= tdo[i];
         end
      end
   endgenerate

   assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(cap));
endmodule

// File: rtl/jtag_bridge.sv
module jtag_bridge
   import jtag_bridge_pkg::*;
#(
   parameter int NCHAIN   = 8,
   parameter int TCK_HALF = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [OP_W-1:0]   bus_op,
   input  logic [NCHAIN-1:0] bus_wdata,
   output logic [NCHAIN-1:0] bus_rdata,
   output logic              busy,
   output logic              wr_err,
   output logic              tck,
   output logic [NCHAIN-1:0] tms,
   output logic [NCHAIN-1:0] tdi,
   input  logic [NCHAIN-1:0] tdo
);
   localparam int PAD = NCHAIN - 2;

   generate
      if (NCHAIN < 2) begin : g_bad_width
         $error("jtag_bridge: NCHAIN must be at least 2");
      end
      if (TCK_HALF < 1) begin : g_bad_half
         $error("jtag_bridge: TCK_HALF must be at least 1");
      end
   endgenerate

   strobe_t           stb;
   logic [NCHAIN-1:0] tdi_q, tms_q, cap;
   logic [NCHAIN-1:0] rd_mux;
   logic              err_q;

   jtag_bridge_decode u_decode (
      .wr   (bus_wr),
      .rd   (bus_rd),
      .op   (bus_op),
      .busy (busy),
      .stb  (stb)
   );

   jtag_bridge_tckgen #(.TCK_HALF(TCK_HALF)) u_tckgen (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (stb.step),
      .tck   (tck),
      .busy  (busy)
   );

   jtag_bridge_capture #(.NCHAIN(NCHAIN)) u_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (stb.step),
      .tdo   (tdo),
      .cap   (cap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdi_q <= '0;
         tms_q <= '1;
      end else begin
         if (stb.ld_tdi) tdi_q <= bus_wdata;
         if (stb.ld_tms) tms_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           err_q <= 1'b0;
      else if (stb.drop)    err_q <= 1'b1;
      else if (stb.clr_err) err_q <= 1'b0;
   end

   always_comb begin
      unique case (bus_op)
         OP_SET_TDI: rd_mux = tdi_q;
         OP_SET_TMS: rd_mux = tms_q;
         OP_STEP:    rd_mux = {{PAD{1'b0}}, err_q, busy};
         OP_GET_TDO: rd_mux = cap;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
      else             bus_rdata <= '0;
   end

   assign tdi    = tdi_q;
   assign tms    = tms_q;
   assign wr_err = err_q;

   assert_drop_sets_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && busy) |=> (wr_err && $stable(tdi) && $stable(tms)));
   assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_op == OP_GET_TDO && !(bus_wr && busy)) |=> !wr_err);
   assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_op[2]) |=> (bus_rdata == '0));
   assert_pins_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(tdi) && $stable(tms)));
endmodule

// File: tb/jtag_bridge_bench.sv
`timescale 1ns/1ps
module jtag_bridge_bench;
   localparam int N = 8;
   localparam int H = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]   bus_op = 3'd0;
   logic [N-1:0] bus_wdata = '0, tdo = '0;
   logic [N-1:0] bus_rdata, tms, tdi;
   logic         busy, wr_err, tck;

   int n_cmp = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   jtag_bridge #(.NCHAIN(N), .TCK_HALF(H)) u_jtag_bridge (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .wr_err(wr_err), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
   );

   // behavioural reference model
   logic [N-1:0] m_tdi, m_tms, m_cap, m_rd;
   logic         m_err;
   int           m_left;

   always @(posedge clk or negedge rst_n) begin
      logic         was_busy;
      logic [N-1:0] rv;
      if (!rst_n) begin
         m_tdi = '0; m_tms = '1; m_cap = '0; m_rd = '0; m_err = 1'b0; m_left = 0;
      end else begin
         was_busy = (m_left > 0);
         rv = '0;
         if (bus_rd) begin
            case (bus_op)
               3'd0: rv = m_tdi;
               3'd1: rv = m_tms;
               3'd2: rv = N'({m_err, was_busy});
               3'd3: rv = m_cap;
               default: rv = '0;
            endcase
         end
         if (bus_wr && was_busy) m_err = 1'b1;
         else if (bus_rd && bus_op == 3'd3) m_err = 1'b0;
         if (m_left > 0) m_left = m_left - 1;
         if (bus_wr && !was_busy) begin
            case (bus_op)
               3'd0: m_tdi = bus_wdata;
               3'd1: m_tms = bus_wdata;
               3'd2: begin m_left = 2 * H; m_cap = tdo; end
               default: ;
            endcase
         end
         m_rd = rv;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [N-1:0] act, input logic [N-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   // continuous comparison on the falling edge
   always @(negedge clk) begin
      chk("R4", "tck",  N'(tck),    N'(m_left > H));
      chk("R4", "busy", N'(busy),   N'(m_left > 0));
      chk("R2", "tdi",  tdi,        m_tdi);
      chk("R3", "tms",  tms,        m_tms);
      chk("R6", "wr_err", N'(wr_err), N'(m_err));
      chk("R8", "rdata", bus_rdata, m_rd);
   end

   task automatic acc(input logic w, input logic r, input logic [2:0] op,
                      input logic [N-1:0] d);
      bus_wr = w; bus_rd = r; bus_op = op; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #7;
      chk("R1", "reset tck/busy/err", N'({tck, busy, wr_err}), '0);
      chk("R1", "reset tms", tms, '1);
      chk("R1", "reset tdi", tdi, '0);
      chk("R1", "reset rdata", bus_rdata, '0);
      @(posedge clk); #1; rst_n = 1'b1;
      idle(2);

      acc(1, 0, 3'd0, 8'hA5);
      chk("R2", "tdi load", tdi, 8'hA5);
      acc(1, 0, 3'd1, 8'h3C);
      chk("R3", "tms load", tms, 8'h3C);
      acc(0, 1, 3'd0, '0);
      chk("R8", "read tdi", bus_rdata, 8'hA5);
      acc(0, 1, 3'd1, '0);
      chk("R8", "read tms", bus_rdata, 8'h3C);

      // reserved writes ignored
      acc(1, 0, 3'd5, 8'hFF);
      acc(1, 0, 3'd3, 8'hFF);
      chk("R9", "reserved write tdi", tdi, 8'hA5);
      chk("R9", "reserved write tms", tms, 8'h3C);
      chk("R9", "reserved write err", N'({wr_err, busy}), '0);
      acc(0, 1, 3'd6, '0);
      chk("R8", "reserved read", bus_rdata, '0);

      // step with capture
      tdo = 8'h5A;
      acc(1, 0, 3'd2, '0);
      chk("R4", "step start", N'({tck, busy}), 8'h03);
      tdo = 8'hC3;
      acc(1, 0, 3'd0, 8'h11);
      chk("R6", "dropped tdi", tdi, 8'hA5);
      chk("R6", "err set", N'(wr_err), 8'h01);
      acc(0, 1, 3'd2, '0);
      chk("R8", "status read", bus_rdata, 8'h03);
      chk("R10", "tms stable in step", tms, 8'h3C);
      // collision: dropped write and err clear in one cycle
      bus_wr = 1'b1; bus_rd = 1'b1; bus_op = 3'd3; bus_wdata = 8'h00;
      @(posedge clk); #1; bus_wr = 1'b0; bus_rd = 1'b0;
      chk("R7", "set beats clear", N'(wr_err), 8'h01);
      chk("R5", "capture during step", bus_rdata, 8'h5A);
      while (busy) begin @(posedge clk); #1; end
      acc(0, 1, 3'd3, '0);
      chk("R5", "capture held", bus_rdata, 8'h5A);
      chk("R7", "err cleared", N'(wr_err), 8'h00);

      // write on the last busy cycle, then on the first idle cycle
      tdo = 8'h96;
      acc(1, 0, 3'd2, '0);
      idle(2 * H - 1);
      chk("R4", "last busy cycle", N'(busy), 8'h01);
      tdo = 8'h0F;
      acc(1, 0, 3'd2, '0);
      chk("R6", "edge write dropped", N'({wr_err, busy}), 8'h02);
      acc(1, 0, 3'd2, '0);
      chk("R4", "restart after idle", N'({tck, busy}), 8'h03);
      idle(2 * H);
      acc(0, 1, 3'd3, '0);
      chk("R5", "new capture", bus_rdata, 8'h0F);

      // random traffic
      for (int k = 0; k < 3000; k++) begin
         tdo = N'($urandom);
         acc(1'($urandom), 1'($urandom), 3'($urandom), N'($urandom));
         if (($urandom % 4) == 0) idle(int'($urandom % 6));
      end
      idle(4);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule